// File: doc/BRIEF.md
# Serial Converter Device-Side Interface

This block sits on the device side of a three-wire serial link and behaves like a 10-bit sampling converter seen from its digital pins. A host drives an active-low select and a serial clock. The block drives one data line, whose output enable stands in for the high-impedance state. A 10-bit straight-binary sample arrives on a parallel input. It is captured at the instant select goes low, and later changes on that input do not reach the word in flight.

Each word is 16 serial-clock periods long. It is made of three zero bits, then the ten sample bits from most to least significant, then three more zero bits. The first bit appears when select falls. Each later bit replaces the previous one on a falling serial-clock edge. The line is released after the sixteenth falling edge and whenever select is high.

When select rises, the number of falling edges counted so far decides what happens:
- Fewer than ten: the block drops into shutdown until the next select fall.
- Ten to fifteen: the word is cut short and flagged by a one-cycle pulse, and the mode stays normal.
- Sixteen or more: the word was complete, and nothing is flagged.

Both host signals pass through two synchroniser flops before edge detection on a fast system clock. An input transition therefore reaches the outputs three system clocks later.

Top module: `adc_serial_dev`

## Requirements
- R1: During and after reset, with select held high, the data enable is low, the shutdown level is high and the abort pulse is low.
- R2: A falling edge on select captures the parallel sample, clears the shutdown level and turns the data enable on.
- R3: After k falling serial-clock edges (k = 0..15) since select fell, the data line carries frame bit k: bits 0-2 are 0, bit 3+j carries sample bit 9-j for j = 0..9, and bits 13-15 are 0.
- R4: From the sixteenth falling edge on, with select still low, the data enable is low and further falling edges change nothing.
- R5: Select rising after fewer than ten falling edges sets the shutdown level and gives no abort pulse.
- R6: Shutdown holds, and the data enable stays low, while select is high, whatever the serial clock does, until select falls again.
- R7: Select rising after ten to fifteen falling edges gives an abort pulse exactly one system clock wide and leaves the shutdown level low.
- R8: Select rising after sixteen or more falling edges gives no abort pulse and leaves the shutdown level low.
- R9: The data enable goes low once a select rise has passed the synchronisers.
- R10: A falling serial-clock edge detected in the same system clock as a select rise is counted before the rise is judged.
- R11: Changes on the parallel sample after select has fallen do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from host, asynchronous |
| csNIn | input | 1 | Active-low select from host, asynchronous |
| sampleIn | input | 10 | Parallel straight-binary sample |
| sdoOut | output | 1 | Serial data bit |
| sdoOe | output | 1 | Data line drive enable (low means high impedance) |
| abortPulse | output | 1 | One-cycle flag for a truncated word |
| shutdownMode | output | 1 | High in shutdown, low in normal mode |

## Verification
Two events can land in the same system clock: a falling serial-clock edge and the rise of select. The bench provokes this by changing both inputs in the same instant. Both then cross synchronisers of equal depth and are detected together. The case is driven just before the tenth edge, where the counted edge has to turn a shutdown into an abort. It is also driven just before the sixteenth, where it has to turn an abort into a clean finish. The bench judges each outcome from the abort-pulse count and the shutdown level, using the edge-counting rule.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

  // Width of the frame-position index carried in the strobe bundle.
  // Frame lengths up to 255 fit.
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             latch;   // capture the parallel sample
    logic             drive;   // data line enabled
    logic [IDX_W-1:0] bitIdx;  // current position inside the frame
  } strobe_t;

endpackage

// File: rtl/adc_serial_sync.sv
module adc_serial_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_serial_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int ABORT_AT  = 10,
  parameter int SYNC_STG  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    csNIn,
  output strobe_t strobe,
  output logic    abortPulse,
  output logic    shutdownMode
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_ABORT = CNT_W'(ABORT_AT);

  logic sclkSync, csSync;
  logic sclkPrev, csPrev;
  logic sclkFall, csFall, csRise;
  logic active;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] effCount;
  logic countStep;

  adc_serial_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) uSyncSclk (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkSync)
  );

  adc_serial_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) uSyncCs (
    .clk(clk), .rstN(rstN), .d(csNIn), .q(csSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkSync;
      csPrev   <= csSync;
    end
  end

  assign sclkFall = sclkPrev & ~sclkSync;
  assign csFall   = csPrev & ~csSync;
  assign csRise   = ~csPrev & csSync;

  // A falling edge seen in the same cycle as the select rise counts first.
  assign countStep = sclkFall && active && (count < CNT_END);
  assign effCount  = count + CNT_W'(countStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active       <= 1'b0;
      count        <= '0;
      shutdownMode <= 1'b1;
      abortPulse   <= 1'b0;
    end else begin
      abortPulse <= 1'b0;
      if (csFall) begin
        active       <= 1'b1;
        count        <= '0;
        shutdownMode <= 1'b0;
      end else if (csRise) begin
        active <= 1'b0;
        count  <= effCount;
        if (active && (effCount < CNT_ABORT)) begin
          shutdownMode <= 1'b1;
        end
        if (active && (effCount >= CNT_ABORT) && (effCount < CNT_END)) begin
          abortPulse <= 1'b1;
        end
      end else if (countStep) begin
        count <= effCount;
      end
    end
  end

  always_comb begin
    strobe.latch  = csFall;
    strobe.drive  = active && (count < CNT_END);
    strobe.bitIdx = IDX_W'(count);
  end

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);  // R7

  AST_ABORT_KEEPS_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !shutdownMode);  // R7

  AST_SHUTDOWN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdownMode) |-> $past(csRise));  // R5

  AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutdownMode) |-> $past(csFall));  // R6

  AST_RELEASE_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !strobe.drive);  // R9

  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && sclkFall && !csRise && count == CNT_END - 1'b1)
      |=> !strobe.drive);  // R4

  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (strobe.drive && !shutdownMode));  // R2

endmodule

// File: rtl/adc_serial_dp.sv
module adc_serial_dp
  import adc_serial_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LEAD_Z = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  strobe_t           strobe,
  output logic              sdoOut,
  output logic              sdoOe
);

  logic [DATA_W-1:0] sampleReg;
  logic frameBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sampleReg <= '0;
    else if (strobe.latch) sampleReg <= sampleIn;
  end

  // Position LEAD_Z carries the MSB; positions outside the data field are 0.
  always_comb begin
    frameBit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (int'(strobe.bitIdx) == LEAD_Z + DATA_W - 1 - i) frameBit = sampleReg[i];
    end
  end

  assign sdoOe  = strobe.drive;
  assign sdoOut = strobe.drive & frameBit;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdoOut);  // R9

  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latch && !$past(strobe.latch)) |-> $stable(sampleReg));  // R11

endmodule

// File: rtl/adc_serial_dev.sv
module adc_serial_dev
  import adc_serial_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_Z    = 3,
  parameter int FRAME_LEN = 16,
  parameter int ABORT_AT  = 10,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic              abortPulse,
  output logic              shutdownMode
);

  strobe_t strobe;

  adc_serial_ctrl #(
    .FRAME_LEN(FRAME_LEN), .ABORT_AT(ABORT_AT), .SYNC_STG(SYNC_STG)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn),
    .strobe(strobe), .abortPulse(abortPulse), .shutdownMode(shutdownMode)
  );

  adc_serial_dp #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z)) uDp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobe(strobe),
    .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (!sdoOe && shutdownMode && !abortPulse));  // R1

endmodule

// File: tb/adc_serial_dev_test.sv
module adc_serial_dev_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b1;
  logic csNIn = 1'b1;
  logic [9:0] sampleIn = '0;
  logic sdoOut, sdoOe, abortPulse, shutdownMode;

  int total = 0;
  int bad = 0;
  int abortCnt = 0;
  bit done = 1'b0;
  localparam int HOLD = 6;

  always #2.5 clk = ~clk;

  adc_serial_dev uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn),
    .sampleIn(sampleIn), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .abortPulse(abortPulse), .shutdownMode(shutdownMode)
  );

  always @(negedge clk) if (abortPulse) abortCnt++;

  function automatic logic expBit(input logic [9:0] s, input int k);
    if (k >= 3 && k < 13) return s[12 - k];
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitHold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic checkBit(input logic [9:0] s, input int k, input string req);
    if (k < 16) begin
      chk(sdoOe === 1'b1, {req, " enable"}, int'(sdoOe), 1);
      chk(sdoOut === expBit(s, k), {req, " bit"}, int'(sdoOut), int'(expBit(s, k)));
    end else begin
      chk(sdoOe === 1'b0, {req, " released"}, int'(sdoOe), 0);
    end
  endtask

  // Runs a frame with n falling edges; if joint, the last edge coincides with the select rise.
  task automatic runFrame(input logic [9:0] s, input int n, input bit joint, input bit scramble);
    int startAborts;
    int effN;
    startAborts = abortCnt;
    sampleIn = s;
    @(negedge clk);
    csNIn = 1'b0;
    waitHold();
    chk(shutdownMode === 1'b0, "R2 normal mode", int'(shutdownMode), 0);
    checkBit(s, 0, "R2/R3");
    if (scramble) sampleIn = 10'($urandom);
    for (int k = 1; k <= n; k++) begin
      if (joint && k == n) begin
        sclkIn = 1'b0;
        csNIn  = 1'b1;
        waitHold();
        sclkIn = 1'b1;
        waitHold();
      end else begin
        sclkIn = 1'b0;
        waitHold();
        checkBit(s, k, (k >= 16) ? "R4" : (scramble ? "R11/R3" : "R3"));
        sclkIn = 1'b1;
        waitHold();
      end
    end
    if (!joint) begin
      csNIn = 1'b1;
      waitHold();
    end
    effN = n;
    chk(sdoOe === 1'b0, "R9 release on select", int'(sdoOe), 0);
    if (effN < 10) begin
      chk(shutdownMode === 1'b1, joint ? "R10 shutdown" : "R5 shutdown", int'(shutdownMode), 1);
      chk(abortCnt == startAborts, "R5 no abort", abortCnt - startAborts, 0);
    end else if (effN < 16) begin
      chk(shutdownMode === 1'b0, joint ? "R10 normal" : "R7 normal", int'(shutdownMode), 0);
      chk(abortCnt == startAborts + 1, joint ? "R10 abort" : "R7 abort once",
          abortCnt - startAborts, 1);
    end else begin
      chk(shutdownMode === 1'b0, "R8 normal", int'(shutdownMode), 0);
      chk(abortCnt == startAborts, joint ? "R10 no abort" : "R8 no abort",
          abortCnt - startAborts, 0);
    end
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    chk(sdoOe === 1'b0, "R1 enable in reset", int'(sdoOe), 0);
    chk(shutdownMode === 1'b1, "R1 shutdown in reset", int'(shutdownMode), 1);
    rstN = 1'b1;
    waitHold();
    chk(sdoOe === 1'b0, "R1 enable after reset", int'(sdoOe), 0);
    chk(shutdownMode === 1'b1, "R1 shutdown after reset", int'(shutdownMode), 1);
    chk(abortPulse === 1'b0, "R1 abort after reset", int'(abortPulse), 0);

    runFrame(10'h2A5, 16, 1'b0, 1'b0);
    runFrame(10'h3FF, 20, 1'b0, 1'b0);
    runFrame(10'h201, 3, 1'b0, 1'b0);

    // R6: serial clock toggles while select is high and shutdown holds
    for (int i = 0; i < 5; i++) begin
      sclkIn = 1'b0; waitHold();
      sclkIn = 1'b1; waitHold();
    end
    chk(shutdownMode === 1'b1, "R6 shutdown held", int'(shutdownMode), 1);
    chk(sdoOe === 1'b0, "R6 enable off", int'(sdoOe), 0);

    runFrame(10'h155, 9, 1'b0, 1'b0);
    runFrame(10'h0F0, 10, 1'b0, 1'b0);
    runFrame(10'h333, 15, 1'b0, 1'b0);
    runFrame(10'h1C3, 10, 1'b1, 1'b0);
    runFrame(10'h0A7, 16, 1'b1, 1'b0);
    runFrame(10'h3C9, 16, 1'b0, 1'b1);
    runFrame(10'h000, 0, 1'b0, 1'b0);

    for (int it = 0; it < 40; it++) begin
      runFrame(10'($urandom), int'($urandom_range(0, 20)), 1'b0, bit'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule